// File: doc/BRIEF.md
# Fractional Divider Trim Sequencer

This block sits between the loop filter of an FPGA-based all-digital PLL and the I2C master that programs an external clock synthesizer. It keeps a local copy of the synthesizer's feedback divider as a 38-bit fixed-point word: 9 integer bits above 29 fraction bits. Each signed correction step from the loop filter is counted in fraction LSBs. One LSB moves the output by about 0.026 ppb, and each higher bit doubles that effect. The block adds the step to the word, so a carry or borrow out of the fraction reaches the integer field. The result is bounded twice. It must stay within a fixed band around a centre value, which matches ±1000 ppm of output frequency. It must also stay inside the synthesizer's absolute legal divider range.

After each update the block sends a burst of five byte writes, each an {address, data} pair on a valid/ready stream, for the I2C master to carry out. The fraction bytes go first, lowest byte first. Next comes a mixed register that packs the low integer bits with the top fraction bits. The burst always ends at address 9, which holds the upper integer bits and commits the new value in the synthesizer. Steps that arrive while a burst is in progress are summed. Their total is applied as a single update in the following burst.

Top module: `frac_trim_seq`

## Requirements
- R1: While reset is high the block loads the centre value, clamped to [DIV_LO, DIV_HI], as both the centre and the current divider. It keeps wr_valid_o and busy_o low until a step arrives. A step of 0 then sends back exactly that clamped centre.
- R2: An accepted step S, a signed count of fraction LSBs, sets the divider to current + S over the full 38-bit word. A carry or borrow out of the 29-bit fraction changes the 9-bit integer field.
- R3: The divider never leaves [DIV_LO, DIV_HI]. Default DIV_LO is 34918433303, about 65.0407 × 2^29. Default DIV_HI is 41969270796, about 78.1739 × 2^29. A result outside this range is set to the nearer bound.
- R4: The divider never moves more than BAND LSBs away from the centre. The default BAND is 38117835, which is 1/1000 of 71 × 2^29. A larger offset is saturated to ±BAND.
- R5: Each update produces exactly five writes, to addresses ADDR_BASE+0 through ADDR_BASE+4 in rising order (5, 6, 7, 8, 9 by default). The last write always goes to address 9.
- R6: Data encoding, with v the 38-bit divider (fraction in v[28:0], integer in v[37:29]). Address 5 carries v[7:0], address 6 carries v[15:8], address 7 carries v[23:16], and address 8 carries {int[2:0], frac[28:24]} = v[31:24]. Address 9 carries {2'b00, int[8:3]}.
- R7: While wr_valid_o is high and wr_ready_i is low, wr_addr_o and wr_data_o hold steady and wr_valid_o stays high.
- R8: Steps accepted during a burst are summed and applied in one further update, then one further burst. Without new steps, no extra burst follows.
- R9: busy_o goes high in the cycle after a step is accepted. It falls in the cycle after the address-9 write is accepted, provided nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| centre_i | input | 38 | Centre divider value, loaded while rst is high |
| step_valid_i | input | 1 | Step strobe, one step per high cycle |
| step_i | input | 32 | Signed correction in fraction LSBs |
| busy_o | output | 1 | Update in progress |
| wr_valid_o | output | 1 | Register write pair available |
| wr_ready_i | input | 1 | Downstream accepts the pair this cycle |
| wr_addr_o | output | 8 | Synthesizer register address |
| wr_data_o | output | 8 | Register data byte |

## Verification
A wrong internal divider shows up on the next burst: the five data bytes put back together do not match current-plus-step after both clamps. An error in the carry or clamp logic is therefore visible within five accepted writes of the step that exposed it. A sequencing error shows up at once on the address stream as a skipped, repeated or reordered address, or a burst that does not end at 9. A lost pending sum shows up as a missing second burst, and a phantom one as an extra burst. Busy can fall early or stay high too long, and either is seen in the cycle after the address-9 handshake.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int INT_W  = 9;
  localparam int FRAC_W = 29;
  localparam int DIV_W  = INT_W + FRAC_W;
  localparam int SUM_W  = DIV_W + 4;
  localparam int NUM_WR = 5;
  localparam int IDX_W  = $clog2(NUM_WR);

  typedef logic [DIV_W-1:0]        div_t;
  typedef logic signed [SUM_W-1:0] wide_t;
  typedef enum logic {ST_IDLE, ST_SEND} seq_st_t;

  function automatic wide_t widen(div_t v);
    return $signed({{(SUM_W-DIV_W){1'b0}}, v});
  endfunction

  // offset from centre saturated to +/-band, then absolute range clamp
  function automatic div_t clamp_div(wide_t sum, div_t ctr, div_t band,
                                     div_t lo, div_t hi);
    wide_t off;
    wide_t bnd;
    wide_t v;
    off = sum - widen(ctr);
    bnd = widen(band);
    if (off > bnd)       off = bnd;
    else if (off < -bnd) off = -bnd;
    v = widen(ctr) + off;
    if (v < widen(lo))      v = widen(lo);
    else if (v > widen(hi)) v = widen(hi);
    return v[DIV_W-1:0];
  endfunction

  // byte k of the write burst; last slot holds the upper integer bits
  function automatic logic [7:0] slice_byte(div_t v, int unsigned k);
    if (k < NUM_WR - 1) return v[8*k +: 8];
    return 8'(v[DIV_W-1:8*(NUM_WR-1)]);
  endfunction
endpackage

// File: rtl/trim_accum.sv
module trim_accum
  import trim_pkg::*;
#(
  parameter int   STEP_W = 32,
  parameter int   ACC_W  = 40,
  parameter div_t DIV_LO = 38'd34918433303,
  parameter div_t DIV_HI = 38'd41969270796,
  parameter div_t BAND   = 38'd38117835
) (
  input  logic                     clk,
  input  logic                     rst,
  input  div_t                     centre_i,
  input  logic                     step_valid_i,
  input  logic signed [STEP_W-1:0] step_i,
  input  logic                     load_i,
  output div_t                     cur_o,
  output logic                     pend_flag_o
);
  div_t                    ctr_q;
  div_t                    cur_q;
  logic signed [ACC_W-1:0] pend_q;
  logic                    pend_flag_q;
  wide_t                   step_w;
  wide_t                   sum_w;
  logic signed [ACC_W-1:0] step_a;

  always_comb begin
    step_w = step_valid_i ? {{(SUM_W-STEP_W){step_i[STEP_W-1]}}, step_i} : '0;
    step_a = {{(ACC_W-STEP_W){step_i[STEP_W-1]}}, step_i};
    sum_w  = widen(cur_q) + {{(SUM_W-ACC_W){pend_q[ACC_W-1]}}, pend_q} + step_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q       <= clamp_div(widen(centre_i), centre_i, BAND, DIV_LO, DIV_HI);
      cur_q       <= clamp_div(widen(centre_i), centre_i, BAND, DIV_LO, DIV_HI);
      pend_q      <= '0;
      pend_flag_q <= 1'b0;
    end else if (load_i) begin
      cur_q       <= clamp_div(sum_w, ctr_q, BAND, DIV_LO, DIV_HI);
      pend_q      <= '0;
      pend_flag_q <= 1'b0;
    end else if (step_valid_i) begin
      pend_q      <= pend_q + step_a;
      pend_flag_q <= 1'b1;
    end
  end

  assign cur_o       = cur_q;
  assign pend_flag_o = pend_flag_q;

  AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (cur_q >= DIV_LO) && (cur_q <= DIV_HI)); // R3
  AST_IN_BAND: assert property (@(posedge clk) disable iff (rst)
    (cur_q >= ctr_q) ? ((cur_q - ctr_q) <= BAND) : ((ctr_q - cur_q) <= BAND)); // R4
endmodule

// File: rtl/trim_burst_seq.sv
module trim_burst_seq
  import trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step_valid_i,
  input  logic             pend_flag_i,
  input  logic             wr_ready_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             wr_valid_o,
  output logic             last_fire_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WR - 1);

  seq_st_t          st_q;
  logic [IDX_W-1:0] idx_q;
  logic             fire;
  logic             last_fire;
  logic             start_ev;

  always_comb begin
    fire      = (st_q == ST_SEND) && wr_ready_i;
    last_fire = fire && (idx_q == LAST_IDX);
    start_ev  = ((st_q == ST_IDLE) && step_valid_i) ||
                (last_fire && (pend_flag_i || step_valid_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (start_ev) begin
      st_q  <= ST_SEND;
      idx_q <= '0;
    end else if (last_fire) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign load_o      = start_ev;
  assign busy_o      = (st_q == ST_SEND);
  assign wr_valid_o  = (st_q == ST_SEND);
  assign last_fire_o = last_fire;
  assign idx_o       = idx_q;

  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(idx_q))); // R7
  AST_NEXT_SLOT: assert property (@(posedge clk) disable iff (rst)
    (fire && !last_fire) |=> (wr_valid_o && (idx_q == $past(idx_q) + 1'b1))); // R5
  AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid_o) |-> (idx_q == '0)); // R5
  AST_END_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> $past(last_fire)); // R9
endmodule

// File: rtl/trim_wr_slicer.sv
module trim_wr_slicer
  import trim_pkg::*;
#(
  parameter logic [7:0] ADDR_BASE = 8'd5
) (
  input  div_t             cur_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       addr_o,
  output logic [7:0]       data_o
);
  logic [7:0] bytes [NUM_WR];

  for (genvar g = 0; g < NUM_WR; g++) begin : g_slice
    assign bytes[g] = slice_byte(cur_i, g);
  end

  always_comb begin
    addr_o = ADDR_BASE + 8'(idx_i);
    data_o = '0;
    for (int k = 0; k < NUM_WR; k++)
      if (idx_i == IDX_W'(k)) data_o = bytes[k];
  end
endmodule

// File: rtl/frac_trim_seq.sv
module frac_trim_seq
  import trim_pkg::*;
#(
  parameter int         STEP_W    = 32,
  parameter int         ACC_W     = 40,
  parameter logic [7:0] ADDR_BASE = 8'd5,
  parameter div_t       DIV_LO    = 38'd34918433303,
  parameter div_t       DIV_HI    = 38'd41969270796,
  parameter div_t       BAND      = 38'd38117835
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [37:0]              centre_i,
  input  logic                     step_valid_i,
  input  logic signed [STEP_W-1:0] step_i,
  output logic                     busy_o,
  output logic                     wr_valid_o,
  input  logic                     wr_ready_i,
  output logic [7:0]               wr_addr_o,
  output logic [7:0]               wr_data_o
);
  localparam logic [7:0] LAST_ADDR = ADDR_BASE + 8'(NUM_WR - 1);

  div_t             cur;
  logic             pend_flag;
  logic             load;
  logic             last_fire;
  logic [IDX_W-1:0] idx;

  trim_accum #(
    .STEP_W(STEP_W), .ACC_W(ACC_W),
    .DIV_LO(DIV_LO), .DIV_HI(DIV_HI), .BAND(BAND)
  ) u_accum (
    .clk(clk), .rst(rst), .centre_i(centre_i),
    .step_valid_i(step_valid_i), .step_i(step_i),
    .load_i(load), .cur_o(cur), .pend_flag_o(pend_flag)
  );

  trim_burst_seq u_seq (
    .clk(clk), .rst(rst), .step_valid_i(step_valid_i),
    .pend_flag_i(pend_flag), .wr_ready_i(wr_ready_i),
    .load_o(load), .busy_o(busy_o), .wr_valid_o(wr_valid_o),
    .last_fire_o(last_fire), .idx_o(idx)
  );

  trim_wr_slicer #(.ADDR_BASE(ADDR_BASE)) u_slicer (
    .cur_i(cur), .idx_i(idx), .addr_o(wr_addr_o), .data_o(wr_data_o)
  );

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    wr_valid_o |-> ((wr_addr_o >= ADDR_BASE) && (wr_addr_o <= LAST_ADDR))); // R5
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> ($stable(wr_data_o) && $stable(wr_addr_o))); // R7
  AST_TOP_BITS: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && (wr_addr_o == LAST_ADDR)) |-> (wr_data_o[7:6] == 2'b00)); // R6
  AST_QUIET_END: assert property (@(posedge clk) disable iff (rst)
    (last_fire && !pend_flag && !step_valid_i) |=> (!busy_o && !wr_valid_o)); // R9
  AST_LAST_ADDR: assert property (@(posedge clk) disable iff (rst)
    last_fire |-> (wr_addr_o == LAST_ADDR)); // R5
endmodule

// File: tb/tb_frac_trim_seq.sv
`timescale 1ns/1ps
module tb_frac_trim_seq;
  localparam longint DIV_LO = 64'd34918433303;
  localparam longint DIV_HI = 64'd41969270796;
  localparam longint BAND   = 64'd38117835;
  localparam longint ONE    = 64'd1 << 29;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [37:0] centre_i = '0;
  logic        step_valid_i = 1'b0;
  logic signed [31:0] step_i = '0;
  logic        busy_o, wr_valid_o, wr_addr_dummy;
  logic        wr_ready_i = 1'b0;
  logic [7:0]  wr_addr_o, wr_data_o;

  frac_trim_seq dut (
    .clk(clk), .rst(rst), .centre_i(centre_i),
    .step_valid_i(step_valid_i), .step_i(step_i),
    .busy_o(busy_o), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always #2 clk = ~clk;
  assign wr_addr_dummy = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int ready_mode = 0;   // 0 always ready, 1 random, 2 held low
  int burst_cnt = 0;
  longint burst_val [256];
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(longint cur, longint s, longint ctr);
    longint v  = cur + s;
    longint lo = ctr - BAND;
    longint hi = ctr + BAND;
    if (lo < DIV_LO) lo = DIV_LO;
    if (hi > DIV_HI) hi = DIV_HI;
    if (v < lo) v = lo;
    if (v > hi) v = hi;
    return v;
  endfunction

  function automatic longint eff_centre(longint c);
    if (c < DIV_LO) return DIV_LO;
    if (c > DIV_HI) return DIV_HI;
    return c;
  endfunction

  // write monitor: chooses ready, then records the pair that fires at the next edge
  int         mon_idx = 0;
  logic [7:0] mon_b [5];
  bit         prev_stall = 0;
  logic [7:0] prev_a, prev_d;
  always @(negedge clk) begin
    if (ready_mode == 0)      wr_ready_i = 1'b1;
    else if (ready_mode == 1) wr_ready_i = (($urandom % 10) < 6);
    else                      wr_ready_i = 1'b0;
    if (rst) begin
      mon_idx = 0;
      prev_stall = 0;
    end else begin
      if (prev_stall)
        chk(wr_valid_o && wr_addr_o == prev_a && wr_data_o == prev_d,
            "R7 stalled pair held", {wr_addr_o, wr_data_o}, {prev_a, prev_d});
      prev_stall = wr_valid_o && !wr_ready_i;
      prev_a = wr_addr_o;
      prev_d = wr_data_o;
      if (wr_valid_o && wr_ready_i) begin
        if (wr_addr_o != 8'(5 + mon_idx))
          chk(0, "R5 address order", wr_addr_o, 5 + mon_idx);
        mon_b[mon_idx] = wr_data_o;
        if (mon_idx == 4) begin
          chk(mon_b[4][7:6] == 2'b00, "R6 top register upper bits", mon_b[4], mon_b[4] & 8'h3f);
          burst_val[burst_cnt % 256] = (longint'(mon_b[4][5:0]) << 32) | (longint'(mon_b[3]) << 24) |
                                       (longint'(mon_b[2]) << 16) | (longint'(mon_b[1]) << 8) |
                                       longint'(mon_b[0]);
          burst_cnt++;
          mon_idx = 0;
        end else mon_idx++;
      end
    end
  end

  longint exp_v, ctr;

  task automatic do_reset(longint c);
    rst = 1'b1;
    centre_i = c[37:0];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ctr = eff_centre(c);
    exp_v = ctr;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!wr_valid_o && !busy_o, "R1 quiet after reset", {wr_valid_o, busy_o}, 0);
    end
  endtask

  task automatic do_step(longint s);
    @(negedge clk);
    step_valid_i = 1'b1;
    step_i = s[31:0];
    @(negedge clk);
    step_valid_i = 1'b0;
    chk(busy_o, "R9 busy after step", busy_o, 1);
  endtask

  task automatic wait_bursts(int target);
    int n = 0;
    while (burst_cnt < target && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(burst_cnt >= target, "R5 burst completes", burst_cnt, target);
  endtask

  task automatic step_and_check(longint s, string req);
    int b0 = burst_cnt;
    do_step(s);
    exp_v = model(exp_v, s, ctr);
    wait_bursts(b0 + 1);
    @(negedge clk);
    chk(!busy_o, "R9 busy low after commit", busy_o, 0);
    chk(burst_val[b0 % 256] == exp_v, req, burst_val[b0 % 256], exp_v);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // centre 71.0
    do_reset(71 * ONE);
    step_and_check(0, "R1 zero step returns centre");
    step_and_check(1, "R2 add one LSB");
    step_and_check(-2, "R2 borrow into integer");
    chk((exp_v >> 29) == 70 && (exp_v & (ONE - 1)) == ONE - 1, "R2 borrow expectation", exp_v >> 29, 70);
    step_and_check(1, "R2 carry back into integer");
    chk(burst_val[(burst_cnt - 1) % 256] == 71 * ONE, "R2 carry restores 71.0", burst_val[(burst_cnt - 1) % 256], 71 * ONE);
    step_and_check(64'sd2147483647, "R4 positive band saturation");
    step_and_check(64'sd2147483647, "R4 stays at band top");
    step_and_check(-64'sd2147483648, "R4 negative move");
    step_and_check(-64'sd2147483648, "R4 negative band saturation");
    // slow downstream for one update
    ready_mode = 1;
    step_and_check(12345, "R7 update under back-pressure");
    ready_mode = 0;

    // R8: steps folded while a burst is held
    begin
      int b0;
      longint first;
      b0 = burst_cnt;
      ready_mode = 2;
      do_step(1000);
      repeat (2) @(negedge clk);
      do_step(-300);
      do_step(50);
      ready_mode = 0;
      first = model(exp_v, 1000, ctr);
      exp_v = model(first, -250, ctr);
      wait_bursts(b0 + 2);
      chk(burst_val[b0 % 256] == first, "R8 first burst value", burst_val[b0 % 256], first);
      chk(burst_val[(b0 + 1) % 256] == exp_v, "R8 pending sum applied", burst_val[(b0 + 1) % 256], exp_v);
      repeat (40) @(negedge clk);
      chk(burst_cnt == b0 + 2, "R8 no extra burst", burst_cnt, b0 + 2);
      chk(!busy_o, "R9 idle after pending drain", busy_o, 0);
    end

    // R3 absolute bounds
    do_reset(65 * ONE + 26843546);
    step_and_check(-64'sd2147483648, "R3 clamp at lower bound");
    chk(exp_v == DIV_LO, "R3 lower bound expectation", exp_v, DIV_LO);
    do_reset(78 * ONE + 80530637);
    step_and_check(64'sd2147483647, "R3 clamp at upper bound");
    do_reset(80 * ONE);
    step_and_check(0, "R1 centre clamped into range");
    chk(exp_v == DIV_HI, "R3 out-of-range centre", exp_v, DIV_HI);

    // random phase
    do_reset(71 * ONE + 12345678);
    for (int i = 0; i < 60; i++) begin
      longint s, s2;
      int b0;
      ready_mode = ($urandom % 3 == 0) ? 0 : 1;
      if ($urandom % 4 == 0) s = longint'($signed($urandom));
      else s = longint'($urandom % 10001) - 5000;
      if ($urandom % 3 == 0) begin
        b0 = burst_cnt;
        s2 = longint'($urandom % 2001) - 1000;
        do_step(s);
        do_step(s2);
        exp_v = model(exp_v, s, ctr);
        wait_bursts(b0 + 1);
        chk(burst_val[b0 % 256] == exp_v, "R2 random first burst", burst_val[b0 % 256], exp_v);
        exp_v = model(exp_v, s2, ctr);
        wait_bursts(b0 + 2);
        chk(burst_val[(b0 + 1) % 256] == exp_v, "R8 random pending burst", burst_val[(b0 + 1) % 256], exp_v);
        repeat (2) @(negedge clk);
      end else begin
        step_and_check(s, "R2 random step");
      end
    end
    ready_mode = 0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", burst_cnt, 0);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule